// File: doc/BRIEF.md
# Complementary Output Generator with Dead Time

This block turns a single PWM waveform into a high-side and low-side drive pair. Each change of the input starts a guard interval during which both drive outputs are forced low. Only when that interval has run out does the output matching the new input level go active. The block holds two such generators side by side. Each one has its own input, its own 8-bit interval and its own enable.

The guard interval is measured in ticks of a prescaled timebase, not in system clock cycles. A single-cycle `tick` strobe, shared by both generators, advances every running interval by one. When a generator is disabled, or its interval is zero, its outputs follow the input and its complement directly, with no added delay. The prescaler, the PWM counter and any register decoding live outside this block.

Top module: `dtime_pair_gen`

## Requirements
- R1: While `rst_n` is low, every `out_hi` and `out_lo` bit is 0, whatever the inputs are.
- R2: When a generator's `dt_en` bit is 0, its `out_hi` equals its `pwm_in` bit and its `out_lo` equals the inverse of that bit, in the same cycle.
- R3: When a generator is enabled with an interval of 0, its outputs follow the input and its complement in the same cycle, with no dead time.
- R4: When a generator is enabled with interval L>0 and `tick` is high every cycle, a rising input forces both outputs low from the cycle of the change. `out_hi` goes to 1 in the (L+1)th cycle after the change.
- R5: The low side behaves the same way on a falling input. Both outputs stay low, and `out_lo` goes to 1 in the (L+1)th cycle after the change.
- R6: The interval counts only cycles in which `tick` is 1. While `tick` stays 0 after an edge, both outputs stay low for as long as it stays 0.
- R7: If the input changes again before the interval has expired, the interval restarts from L at the new change. Neither output goes active in between.
- R8: The two generators are independent. Activity, interval and enable of generator 0 (interval in `dt_len[7:0]`) do not affect generator 1 (interval in `dt_len[15:8]`), and the reverse also holds.
- R9: `out_hi` and `out_lo` of the same generator are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled timebase strobe, one cycle wide |
| pwm_in | input | NUM_GEN | PWM waveform, one bit per generator |
| dt_en | input | NUM_GEN | Dead-time enable, one bit per generator |
| dt_len | input | NUM_GEN*DT_W | Dead interval in ticks; generator g uses bits [g*DT_W +: DT_W] |
| out_hi | output | NUM_GEN | High-side drive, active high |
| out_lo | output | NUM_GEN | Low-side drive, active high |

## Verification
The dead-time and rise properties assume that `dt_len` and `dt_en` change only while the input is steady. In that case a change of either one is never mistaken for a timing violation. The stimulus changes configuration only on a cycle where the input is either steady or the interval is being reloaded anyway. It also raises the enable only after the interval has drained. Inputs are driven only on falling clock edges, so every sampled input is settled before the rising edge that registers it.

// File: rtl/dtime_pair_gen.sv
module dtime_pair_gen #(
  parameter int NUM_GEN = 2,
  parameter int DT_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic [NUM_GEN-1:0]      pwm_in,
  input  logic [NUM_GEN-1:0]      dt_en,
  input  logic [NUM_GEN*DT_W-1:0] dt_len,
  output logic [NUM_GEN-1:0]      out_hi,
  output logic [NUM_GEN-1:0]      out_lo
);

  for (genvar g = 0; g < NUM_GEN; g++) begin : gen_ch
    logic [DT_W-1:0] len, cnt;
    logic            pwm_q, edge_now, busy, bypass;

    assign len      = dt_len[g*DT_W +: DT_W];
    assign edge_now = pwm_in[g] ^ pwm_q;
    assign busy     = (cnt != '0);
    assign bypass   = !dt_en[g] || (len == '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pwm_q <= 1'b0;
        cnt   <= '0;
      end else begin
        pwm_q <= pwm_in[g];
        if (edge_now)         cnt <= len;
        else if (busy && tick) cnt <= cnt - 1'b1;
      end
    end

    assign out_hi[g] = rst_n && (bypass ?  pwm_in[g] : ( pwm_in[g] && !busy && !edge_now));
    assign out_lo[g] = rst_n && (bypass ? !pwm_in[g] : (!pwm_in[g] && !busy && !edge_now));

    // R9
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_hi[g] && out_lo[g]));

    // R2
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dt_en[g] |-> (out_hi[g] == pwm_in[g]) && (out_lo[g] == !pwm_in[g]));

    // R4
    dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dt_en[g] && $past(dt_en[g]) && len != '0 && pwm_in[g] != $past(pwm_in[g]))
        |-> (!out_hi[g] && !out_lo[g]));

    // R7
    rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(out_hi[g]) && dt_en[g] && $past(dt_en[g]) && len != '0 && $stable(len))
        |-> (pwm_in[g] && $past(pwm_in[g])));
  end

endmodule

// File: tb/dtime_pair_gen_tb_top.sv
`timescale 1ns/1ps
module dtime_pair_gen_tb_top;
  localparam int NG = 2;
  localparam int DW = 8;
  localparam int NV = 21;

  logic clk = 1'b0;
  logic rst_n;
  logic tick;
  logic [NG-1:0]    pwm_in, dt_en, out_hi, out_lo;
  logic [NG*DW-1:0] dt_len;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dtime_pair_gen #(.NUM_GEN(NG), .DT_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwm_in(pwm_in),
    .dt_en(dt_en), .dt_len(dt_len), .out_hi(out_hi), .out_lo(out_lo));

  // {en, len, pwm, exp_hi, exp_lo} for generator 0, tick high every cycle
  localparam logic [11:0] VEC [0:NV-1] = '{
    {1'b1, 8'd2, 1'b0, 1'b0, 1'b1},
    {1'b1, 8'd2, 1'b1, 1'b0, 1'b0},
    {1'b1, 8'd2, 1'b1, 1'b0, 1'b0},
    {1'b1, 8'd2, 1'b1, 1'b0, 1'b0},
    {1'b1, 8'd2, 1'b1, 1'b1, 1'b0},
    {1'b1, 8'd2, 1'b0, 1'b0, 1'b0},
    {1'b1, 8'd2, 1'b0, 1'b0, 1'b0},
    {1'b1, 8'd2, 1'b0, 1'b0, 1'b0},
    {1'b1, 8'd2, 1'b0, 1'b0, 1'b1},
    {1'b1, 8'd3, 1'b1, 1'b0, 1'b0},
    {1'b1, 8'd3, 1'b0, 1'b0, 1'b0},
    {1'b1, 8'd3, 1'b0, 1'b0, 1'b0},
    {1'b1, 8'd3, 1'b0, 1'b0, 1'b0},
    {1'b1, 8'd3, 1'b0, 1'b0, 1'b0},
    {1'b1, 8'd3, 1'b0, 1'b0, 1'b1},
    {1'b1, 8'd0, 1'b1, 1'b1, 1'b0},
    {1'b1, 8'd0, 1'b0, 1'b0, 1'b1},
    {1'b0, 8'd5, 1'b1, 1'b1, 1'b0},
    {1'b0, 8'd5, 1'b1, 1'b1, 1'b0},
    {1'b0, 8'd0, 1'b0, 1'b0, 1'b1},
    {1'b1, 8'd0, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {hi,lo} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n  = 1'b0;
    tick   = 1'b1;
    pwm_in = 2'b11;
    dt_en  = 2'b11;
    dt_len = {8'd7, 8'd2};
    repeat (3) @(negedge clk);
    #1;
    // R1: both sides low during reset
    chk("R1 gen0", {out_hi[0], out_lo[0]}, 2'b00);
    chk("R1 gen1", {out_hi[1], out_lo[1]}, 2'b00);
    pwm_in = 2'b00;
    @(negedge clk);
    rst_n = 1'b1;

    // table: R2 R3 R4 R5 R7 R9 on gen0, R8 on gen1 (held quiet)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      dt_en[0]      = VEC[i][11];
      dt_len[7:0]   = VEC[i][10:3];
      pwm_in[0]     = VEC[i][2];
      #1;
      chk($sformatf("R4/R5/R7/R3/R2 row %0d", i), {out_hi[0], out_lo[0]}, VEC[i][1:0]);
      chk($sformatf("R8 gen1 row %0d", i), {out_hi[1], out_lo[1]}, 2'b01);
      chk("R9 excl", {1'b0, out_hi[0] & out_lo[0]}, 2'b00);
    end

    // R6: interval advances only on tick
    @(negedge clk);
    tick = 1'b0;
    dt_len[15:8] = 8'd2;
    pwm_in[1] = 1'b1;
    #1;
    chk("R6 edge", {out_hi[1], out_lo[1]}, 2'b00);
    repeat (10) @(negedge clk);
    #1;
    chk("R6 no tick hold", {out_hi[1], out_lo[1]}, 2'b00);
    chk("R8 gen0 steady", {out_hi[0], out_lo[0]}, 2'b01);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    #1;
    chk("R6 one tick", {out_hi[1], out_lo[1]}, 2'b00);
    repeat (3) @(negedge clk);
    #1;
    chk("R6 still waiting", {out_hi[1], out_lo[1]}, 2'b00);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    #1;
    chk("R6 second tick", {out_hi[1], out_lo[1]}, 2'b10);

    // R1: reset again while input high
    rst_n = 1'b0;
    @(negedge clk);
    #1;
    chk("R1 reentry", {out_hi, out_lo}, 4'b0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule